// File: doc/BRIEF.md
# Column-Flag Guided Word Repair Sequencer

This block repairs one block of stored words after the column current sensors of that block report an upset. The sensors give a pulse and a vector with one flag per stored column. The flags say which columns were disturbed, but not which words. The sequencer captures the flags and the block number. It then reads every word of that block, one word at a time. For each word it recomputes the interleaved group checks. For every failing check, it inverts the single flagged bit in that group. A changed word is written back through the same port.

The code uses interleaved groups. Stored column `c` belongs to group `c mod GRP`. The data occupies columns `0..DATA_W-1` and the check bits occupy columns `DATA_W..DATA_W+GRP-1`. A correctly encoded word has even parity over every group. Any burst of up to `GRP` neighbouring columns therefore touches each group at most once, and this holds for the check-bit columns too. So one flagged column per failing group is enough to locate the error. No syndrome decoding is needed.

Top module: `colsense_repair`

## Requirements
- R1: Without a pulse on `sense_err_i`, the block stays idle: `busy_o` is low and no read or write is issued.
- R2: A pass reads exactly the words of the triggered block, at addresses `{blk, 0}` up to `{blk, WORDS-1}` in increasing order. Read data is taken one cycle after the read strobe. A write-back uses the address of the word just read.
- R3: A group fails when the XOR of all stored columns `c` with `c mod GRP == g` is 1. A word with no failing group is not written.
- R4: For each failing group with exactly one flagged column, that column's bit is inverted. A burst of up to `GRP` adjacent flipped columns in a word is restored to its encoded value. Only words that changed are written.
- R5: Check-bit columns (`DATA_W` and up) are valid correction targets and are repaired like data columns.
- R6: Upsets that span two neighbouring words of the block are both repaired in the same pass.
- R7: The column flags and the block number are captured when `sense_err_i` is high. Later changes on `col_flag_i` have no effect on the pass.
- R8: A failing group with zero or with several flagged columns sets `uncorr_o`. That word is not written. `uncorr_o` stays set until reset.
- R9: `busy_o` rises on the second clock edge after the sensor pulse and stays high until the pass ends. `done_o` is then a one-cycle pulse with `busy_o` low.
- R10: A sensor pulse that arrives during a pass is held, and its pass starts right after `done_o`.
- R11: After reset, `busy_o`, `done_o`, `uncorr_o`, `mem_rd_o` and `mem_wr_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_err_i | input | 1 | Sensor error pulse; starts or queues a pass |
| sense_blk_i | input | BLK_W | Block whose sensors fired |
| col_flag_i | input | W | One flag per stored column |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle pulse at the end of a pass |
| uncorr_o | output | 1 | Sticky: a word could not be located |
| mem_rd_o | output | 1 | Read strobe; data returns one cycle later |
| mem_wr_o | output | 1 | Write strobe for a repaired word |
| mem_addr_o | output | BLK_W+IDX_W | Word address `{block, index}` |
| mem_rdata_i | input | W | Read data |
| mem_wdata_o | output | W | Repaired word |

## Verification
The main function is driven with four flag patterns.

- A three-column burst inside the data columns shows that each failing group is located separately.
- A pair of neighbouring words hit by one event, under a shared flag set, shows that flags in passing groups cause no change.
- A burst confined to check-bit columns shows that check columns are repaired like data columns.
- Two ambiguous patterns (two flags in a failing group, and no flag in a failing group) tell a located error apart from an unlocatable one.

Each write is compared with a per-address model of the encoded contents. Garbage on the flag input after every trigger and a second trigger during a pass test that the capture and queuing hold.

// File: rtl/colsense_pkg.sv
package colsense_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LATCH,
    S_READ,
    S_CHECK,
    S_WB,
    S_NEXT,
    S_DONE
  } seq_st_e;

  // group a stored column belongs to
  function automatic int grp_of(input int col, input int grp);
    return col % grp;
  endfunction

endpackage

// File: rtl/grp_locator.sv
module grp_locator
  import colsense_pkg::*;
#(
  parameter int W   = 12,
  parameter int GRP = 4
) (
  input  logic [W-1:0] word_i,
  input  logic [W-1:0] flags_i,
  output logic [W-1:0] fix_o,
  output logic         bad_o,
  output logic         need_o
);

  logic [GRP-1:0] fail;
  logic [GRP-1:0] bad;

  for (genvar g = 0; g < GRP; g++) begin : g_grp
    logic par, one, many;
    always_comb begin
      par  = 1'b0;
      one  = 1'b0;
      many = 1'b0;
      for (int c = 0; c < W; c++) begin
        if (grp_of(c, GRP) == g) begin
          par = par ^ word_i[c];
          if (flags_i[c]) begin
            many = many | one;
            one  = 1'b1;
          end
        end
      end
    end
    assign fail[g] = par;
    assign bad[g]  = par & (~one | many);
  end

  for (genvar c = 0; c < W; c++) begin : g_col
    assign fix_o[c] = flags_i[c] & fail[c % GRP];
  end

  assign bad_o  = |bad;
  assign need_o = |fix_o;

endmodule

// File: rtl/word_walker.sv
module word_walker #(
  parameter int WORDS = 256,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);

  always_ff @(posedge clk) begin
    if (rst || clr_i) idx_o <= '0;
    else if (inc_i)   idx_o <= idx_o + 1'b1;
  end

  assign last_o = (idx_o == IDX_W'(WORDS - 1));

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    inc_i |-> !last_o);  // R2

endmodule

// File: rtl/colsense_repair.sv
module colsense_repair
  import colsense_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GRP    = 4,
  parameter int WORDS  = 256,
  parameter int NBLK   = 4,
  localparam int W      = DATA_W + GRP,
  localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BLK_W  = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int ADDR_W = BLK_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sense_err_i,
  input  logic [BLK_W-1:0]  sense_blk_i,
  input  logic [W-1:0]      col_flag_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              uncorr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [W-1:0]      mem_rdata_i,
  output logic [W-1:0]      mem_wdata_o
);

  seq_st_e          st;
  logic             pend;
  logic [BLK_W-1:0] cap_blk, blk_q;
  logic [W-1:0]     cap_flags, flags_q, wdata_q, fix;
  logic             bad_any, need_wr, uncorr_q;
  logic [IDX_W-1:0] idx;
  logic             idx_last;

  grp_locator #(.W(W), .GRP(GRP)) u_loc (
    .word_i (mem_rdata_i),
    .flags_i(flags_q),
    .fix_o  (fix),
    .bad_o  (bad_any),
    .need_o (need_wr)
  );

  word_walker #(.WORDS(WORDS)) u_walk (
    .clk   (clk),
    .rst   (rst),
    .clr_i (st == S_LATCH),
    .inc_i ((st == S_NEXT) && !idx_last),
    .idx_o (idx),
    .last_o(idx_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      pend      <= 1'b0;
      cap_blk   <= '0;
      cap_flags <= '0;
      blk_q     <= '0;
      flags_q   <= '0;
      wdata_q   <= '0;
      uncorr_q  <= 1'b0;
    end else begin
      if (sense_err_i) begin
        cap_blk   <= sense_blk_i;
        cap_flags <= col_flag_i;
        pend      <= 1'b1;
      end
      case (st)
        S_IDLE: if (pend) begin
          st      <= S_LATCH;
          flags_q <= cap_flags;
          blk_q   <= cap_blk;
          pend    <= sense_err_i;
        end
        S_LATCH: st <= S_READ;
        S_READ:  st <= S_CHECK;
        S_CHECK: begin
          wdata_q <= mem_rdata_i ^ fix;
          if (bad_any) begin
            uncorr_q <= 1'b1;
            st       <= S_NEXT;
          end else if (need_wr) begin
            st <= S_WB;
          end else begin
            st <= S_NEXT;
          end
        end
        S_WB:   st <= S_NEXT;
        S_NEXT: st <= idx_last ? S_DONE : S_READ;
        S_DONE: begin
          flags_q <= '0;
          if (pend) begin
            st      <= S_LATCH;
            flags_q <= cap_flags;
            blk_q   <= cap_blk;
            pend    <= sense_err_i;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st != S_IDLE) && (st != S_DONE);
  assign done_o      = (st == S_DONE);
  assign uncorr_o    = uncorr_q;
  assign mem_rd_o    = (st == S_READ);
  assign mem_wr_o    = (st == S_WB);
  assign mem_addr_o  = {blk_q, idx};
  assign mem_wdata_o = wdata_q;

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_o && mem_wr_o));  // R2
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!mem_rd_o && !mem_wr_o));  // R1
  AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> $stable(mem_addr_o));  // R2
  AST_UNCORR_STICKY: assert property (@(posedge clk) disable iff (rst)
    uncorr_o |=> uncorr_o);  // R8
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
    (st == S_READ || st == S_CHECK || st == S_WB || st == S_NEXT) |=> $stable(flags_q));  // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);  // R9

endmodule

// File: tb/colsense_repair_tb.sv
`timescale 1ns/1ps
module colsense_repair_tb;
  localparam int DATA_W = 8;
  localparam int GRP    = 4;
  localparam int WORDS  = 16;
  localparam int NBLK   = 2;
  localparam int W      = DATA_W + GRP;
  localparam int DEPTH  = WORDS * NBLK;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sense_err_i = 1'b0;
  logic [0:0] sense_blk_i = '0;
  logic [W-1:0] col_flag_i = '0;
  logic busy_o, done_o, uncorr_o, mem_rd_o, mem_wr_o;
  logic [4:0] mem_addr_o;
  logic [W-1:0] mem_rdata_i, mem_wdata_o;

  logic [W-1:0] mem [DEPTH];
  int nchk = 0, nfail = 0, done_cnt = 0, rd_cnt = 0, wr_cnt = 0;
  logic done_prev = 1'b0;
  int rdq[$];
  int wrq[$];

  always #2.5 clk = ~clk;

  colsense_repair #(.DATA_W(DATA_W), .GRP(GRP), .WORDS(WORDS), .NBLK(NBLK)) u_dut (
    .clk(clk), .rst(rst), .sense_err_i(sense_err_i), .sense_blk_i(sense_blk_i),
    .col_flag_i(col_flag_i), .busy_o(busy_o), .done_o(done_o), .uncorr_o(uncorr_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
    .mem_rdata_i(mem_rdata_i), .mem_wdata_o(mem_wdata_o));

  function automatic logic [W-1:0] clean_word(input int a);
    logic [W-1:0] w;
    w = '0;
    w[DATA_W-1:0] = DATA_W'(a * 29 + 11);
    for (int p = DATA_W; p < W; p++)
      for (int i = 0; i < DATA_W; i++)
        if (i % GRP == p % GRP) w[p] = w[p] ^ w[i];
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model, one cycle read latency
  always @(posedge clk) begin
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
    if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  // per-clock comparison against expected port traffic
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd_o) begin
        rd_cnt++;
        if (rdq.size() == 0) chk(1'b0, "R2", "unexpected read", 64'(mem_addr_o), 64'h0);
        else begin
          int e;
          e = rdq.pop_front();
          chk(int'(mem_addr_o) == e, "R2", "read address", 64'(mem_addr_o), 64'(e));
        end
      end
      if (mem_wr_o) begin
        wr_cnt++;
        if (wrq.size() == 0) chk(1'b0, "R3", "unexpected write", 64'(mem_addr_o), 64'h0);
        else begin
          int e;
          e = wrq.pop_front();
          chk(int'(mem_addr_o) == e, "R4", "write address", 64'(mem_addr_o), 64'(e));
          chk(mem_wdata_o == clean_word(e), "R4", "write data", 64'(mem_wdata_o), 64'(clean_word(e)));
        end
      end
      if (done_o) begin
        done_cnt++;
        chk(!busy_o, "R9", "busy during done", 64'(busy_o), 64'h0);
        chk(!done_prev, "R9", "done longer than one cycle", 64'(done_prev), 64'h0);
      end
      done_prev <= done_o;
    end
  end

  task automatic fill();
    for (int a = 0; a < DEPTH; a++) mem[a] = clean_word(a);
  endtask

  task automatic push_reads(input int blk);
    for (int i = 0; i < WORDS; i++) rdq.push_back(blk * WORDS + i);
  endtask

  task automatic trig(input int blk, input logic [W-1:0] f);
    @(negedge clk);
    sense_err_i = 1'b1;
    sense_blk_i = 1'(blk);
    col_flag_i  = f;
    @(negedge clk);
    sense_err_i = 1'b0;
    col_flag_i  = '1;  // garbage after capture (R7)
  endtask

  task automatic wait_done(input int target);
    while (done_cnt < target) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_mem(input string req, input int skip_a, input logic [W-1:0] skip_v,
                         input int skip_b, input logic [W-1:0] skip_w);
    int bad;
    bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      logic [W-1:0] e;
      e = clean_word(a);
      if (a == skip_a) e = skip_v;
      if (a == skip_b) e = skip_w;
      if (mem[a] !== e) bad++;
    end
    chk(bad == 0, req, "memory image mismatches", 64'(bad), 64'h0);
  endtask

  initial begin
    int base_rd;
    fill();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !uncorr_o && !mem_rd_o && !mem_wr_o, "R11", "reset outputs",
        {59'h0, busy_o, done_o, uncorr_o, mem_rd_o, mem_wr_o}, 64'h0);

    // R1: idle without sensor pulse
    col_flag_i = '1;
    repeat (20) @(negedge clk);
    chk(rd_cnt == 0 && wr_cnt == 0 && !busy_o, "R1", "activity without pulse", 64'(rd_cnt + wr_cnt), 64'h0);

    // R4/R3/R7/R9: three-column burst in block 1 word 5
    fill();
    mem[21] = mem[21] ^ 12'h01C;
    push_reads(1);
    wrq.push_back(21);
    trig(1, 12'h01C);
    @(negedge clk);
    chk(busy_o, "R9", "busy after trigger", 64'(busy_o), 64'h1);
    wait_done(1);
    cmp_mem("R4", -1, '0, -1, '0);
    chk(wr_cnt == 1, "R3", "writes in burst pass", 64'(wr_cnt), 64'h1);
    chk(rdq.size() == 0 && wrq.size() == 0, "R2", "pending expectations", 64'(rdq.size() + wrq.size()), 64'h0);
    chk(!uncorr_o, "R8", "uncorrectable after clean repair", 64'(uncorr_o), 64'h0);

    // R6/R5/R10: two-word span in block 1, then queued check-column burst in block 0
    mem[25] = mem[25] ^ 12'h009;
    mem[26] = mem[26] ^ 12'h002;
    mem[2]  = mem[2]  ^ 12'h600;
    push_reads(1);
    wrq.push_back(25);
    wrq.push_back(26);
    push_reads(0);
    wrq.push_back(2);
    trig(1, 12'h00B);
    repeat (5) @(negedge clk);
    chk(busy_o, "R10", "second pulse lands during pass", 64'(busy_o), 64'h1);
    trig(0, 12'h600);
    wait_done(3);
    chk(done_cnt == 3, "R10", "passes completed", 64'(done_cnt), 64'h3);
    chk(mem[25] == clean_word(25) && mem[26] == clean_word(26), "R6", "span words",
        64'({mem[25], mem[26]}), 64'({clean_word(25), clean_word(26)}));
    chk(mem[2] == clean_word(2), "R5", "check-column repair", 64'(mem[2]), 64'(clean_word(2)));
    chk(wr_cnt == 4, "R4", "total writes", 64'(wr_cnt), 64'h4);
    cmp_mem("R6", -1, '0, -1, '0);

    // R8: two flags in a failing group, and none in another failing group
    mem[3] = mem[3] ^ 12'h001;
    mem[7] = mem[7] ^ 12'h002;
    base_rd = wr_cnt;
    push_reads(0);
    trig(0, 12'h011);
    wait_done(4);
    chk(uncorr_o, "R8", "uncorrectable flag", 64'(uncorr_o), 64'h1);
    chk(wr_cnt == base_rd, "R8", "writes on unlocatable words", 64'(wr_cnt - base_rd), 64'h0);
    cmp_mem("R8", 3, clean_word(3) ^ 12'h001, 7, clean_word(7) ^ 12'h002);

    // R8 sticky across a clean pass
    push_reads(1);
    trig(1, 12'h0FF);
    wait_done(5);
    chk(uncorr_o, "R8", "sticky after clean pass", 64'(uncorr_o), 64'h1);
    chk(rdq.size() == 0 && wrq.size() == 0, "R2", "pending expectations at end", 64'(rdq.size() + wrq.size()), 64'h0);

    // R11: reset clears sticky flag
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!uncorr_o && !busy_o, "R11", "reset clears flags", 64'({uncorr_o, busy_o}), 64'h0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R9 watchdog: got busy %0d expected finished run", busy_o);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule